// File: doc/BRIEF.md
# Vector Register Rename Table with Per-Half Zero Flags

This block keeps the speculative name map for a small set of wide architectural vector registers. Each register is split into a lower and an upper half. Each half is either backed by one physical register file slot or marked zero by a flag in the table. Zeroing idioms and the upper-half clear operation only set flags. They release the physical slot the half held and write no data. A write to the narrow (lower-only) view also marks the upper half zero and gives its slot back.

Branches take checkpoints of the map and the zero flags, with up to `NCKPT` outstanding. A slot released while a branch is unresolved is parked in a holding set owned by the youngest open checkpoint. When that branch resolves correctly, the parked slots join the free pool. A mispredict restores the map and flags of the oldest open checkpoint, drops every younger one, and rebuilds the free pool from the restored map. A slot released by a wrong-path upper-half clear therefore returns to its register and is never left in the pool. A lookup port reports the slot and zero flag of both halves of any register.

Top module: `vrz_rename`

## Requirements
- R1: After reset every half of every register has its zero flag set, all `NPHYS` slots are free, `br_ready` is 1 and `br_tag` is 0.
- R2: A rename with `rn_zero=0` and `rn_uclr=0` gives each half selected in `rn_mask` (bit 0 lower, bit 1 upper) a new slot and clears its zero flag. The lowest-numbered free slots are used, and the lower half gets the lower number. The lookup port shows the new mapping in the cycle after the accepting edge.
- R3: A zeroing idiom (`rn_zero=1`) sets the zero flags of the selected halves and takes no slot. It is accepted even when no slot is free.
- R4: A rename whose mask selects only the lower half, zeroing or not, also sets the upper zero flag and releases the upper slot.
- R5: An upper-half clear (`rn_uclr=1`, mask ignored) sets the upper zero flag, releases the upper slot and leaves the lower half unchanged.
- R6: With no branch open, a released slot is free from the next cycle and is the first one reused if it is the lowest free slot.
- R7: No physical slot is ever mapped by two halves whose zero flags are clear, and no mapped slot is in the free pool.
- R8: `rn_ready` is 0 when fewer slots are free than the request needs. A request offered while `rn_ready` is 0 changes nothing.
- R9: A branch issue (`br_valid` with `br_ready`) opens a checkpoint with tag `br_tag`. Tags count up modulo `NCKPT`. `br_ready` is 0 while `NCKPT` checkpoints are open, and a branch offered then is dropped.
- R10: Branches resolve oldest first, and `rs_tag` names the oldest open checkpoint. Slots released after a checkpoint opened stay out of the free pool until that checkpoint resolves correctly, and then become free.
- R11: On a mispredict, the map and zero flags return to their values at the checkpoint. Slots released on the wrong path are reattached and slots allocated there become free again. All open checkpoints are dropped, and a rename or branch offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_dst | input | $clog2(NARCH) | Destination architectural register |
| rn_mask | input | 2 | Halves written: bit 0 lower, bit 1 upper |
| rn_zero | input | 1 | Request is a zeroing idiom |
| rn_uclr | input | 1 | Request is an upper-half clear |
| rn_ready | output | 1 | Enough free slots for the offered request |
| br_valid | input | 1 | Branch issue, opens a checkpoint |
| br_ready | output | 1 | A checkpoint can be opened |
| br_tag | output | $clog2(NCKPT) | Tag the next checkpoint will get |
| rs_valid | input | 1 | Branch resolution present |
| rs_tag | input | $clog2(NCKPT) | Tag being resolved (oldest open) |
| rs_mispredict | input | 1 | Resolution is a mispredict |
| lk_idx | input | $clog2(NARCH) | Register to look up |
| lk_lo_slot | output | $clog2(NPHYS) | Slot of the lower half |
| lk_lo_zero | output | 1 | Lower half is zero |
| lk_hi_slot | output | $clog2(NPHYS) | Slot of the upper half |
| lk_hi_zero | output | 1 | Upper half is zero |

## Verification
The bench builds the table with four registers, four checkpoints and only ten physical slots. With eight live halves plus slots parked behind an open branch, ten slots run out after three wide writes inside one branch window. This brings the empty-pool stall and zero-idiom acceptance without storage within reach of short directed sequences. The same small pool makes the mispredict recovery test sharp. The wrong path releases slots by an upper-half clear, a narrow write and an upper-only write, and drains the pool completely. After recovery, the exact restored slot numbers and the allocation order show whether the pool was rebuilt correctly.

// File: rtl/vrz_pkg.sv
`timescale 1ns/1ps
package vrz_pkg;

    localparam int HALF_LO = 0;
    localparam int HALF_HI = 1;

    // What a rename does to one half of the destination register
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_ALLOC = 2'd1,
        ACT_ZERO  = 2'd2
    } half_act_e;

    // Number of physical slots a rename request consumes
    function automatic logic [1:0] slots_needed(input logic [1:0] mask,
                                                input logic       zidiom,
                                                input logic       uclr);
        if (uclr || zidiom) return 2'd0;
        return {1'b0, mask[0]} + {1'b0, mask[1]};
    endfunction

endpackage

// File: rtl/vrz_free_pick.sv
`timescale 1ns/1ps
module vrz_free_pick #(
    parameter int NPHYS = 12,
    parameter int SW    = 4,
    parameter int FW    = 4
) (
    input  logic [NPHYS-1:0] free_vec,
    output logic [SW-1:0]    first_idx,
    output logic [SW-1:0]    second_idx,
    output logic [FW-1:0]    nfree
);

    logic got_first, got_second;

    always_comb begin
        first_idx  = '0;
        second_idx = '0;
        nfree      = '0;
        got_first  = 1'b0;
        got_second = 1'b0;
        for (int i = 0; i < NPHYS; i++) begin
            if (free_vec[i]) begin
                nfree = nfree + FW'(1);
                if (!got_first) begin
                    first_idx = SW'(i);
                    got_first = 1'b1;
                end else if (!got_second) begin
                    second_idx = SW'(i);
                    got_second = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vrz_ckpt_store.sv
`timescale 1ns/1ps
module vrz_ckpt_store #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/vrz_rename.sv
`timescale 1ns/1ps
module vrz_rename
    import vrz_pkg::*;
#(
    parameter int NARCH = 4,
    parameter int NPHYS = 12,
    parameter int NCKPT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rn_valid,
    input  logic [$clog2(NARCH)-1:0] rn_dst,
    input  logic [1:0]               rn_mask,
    input  logic                     rn_zero,
    input  logic                     rn_uclr,
    output logic                     rn_ready,
    input  logic                     br_valid,
    output logic                     br_ready,
    output logic [$clog2(NCKPT)-1:0] br_tag,
    input  logic                     rs_valid,
    input  logic [$clog2(NCKPT)-1:0] rs_tag,
    input  logic                     rs_mispredict,
    input  logic [$clog2(NARCH)-1:0] lk_idx,
    output logic [$clog2(NPHYS)-1:0] lk_lo_slot,
    output logic                     lk_lo_zero,
    output logic [$clog2(NPHYS)-1:0] lk_hi_slot,
    output logic                     lk_hi_zero
);

    localparam int SW    = $clog2(NPHYS);
    localparam int CTW   = $clog2(NCKPT);
    localparam int FW    = $clog2(NPHYS + 1);
    localparam int SNAPW = NARCH * 2 * SW + NARCH * 2;

    typedef logic [NARCH-1:0][1:0][SW-1:0] map_t;
    typedef logic [NARCH-1:0][1:0]         zf_t;

    typedef struct packed {
        map_t                        map;
        zf_t                         zf;
        logic [NPHYS-1:0]            free;
        logic [NCKPT-1:0][NPHYS-1:0] held;
        logic [CTW-1:0]              head;
        logic [CTW:0]                cnt;
    } state_t;

    state_t           s_d, s_q;
    logic [SW-1:0]    first_idx, second_idx;
    logic [FW-1:0]    nfree;
    logic [1:0]       need;
    logic             flush, rn_fire, br_fire;
    half_act_e        act [2];
    logic [1:0][SW-1:0] pick;
    logic [NPHYS-1:0] rel, take;
    logic [CTW-1:0]   yidx;
    logic [SNAPW-1:0] ck_wdata, ck_rdata;
    map_t             snap_map;
    zf_t              snap_zf;

    // ---- free slot selection --------------------------------------------
    vrz_free_pick #(.NPHYS(NPHYS), .SW(SW), .FW(FW)) u_pick (
        .free_vec  (s_q.free),
        .first_idx (first_idx),
        .second_idx(second_idx),
        .nfree     (nfree)
    );

    // ---- checkpoint snapshots (map and zero flags) ----------------------
    vrz_ckpt_store #(.W(SNAPW), .DEPTH(NCKPT), .AW(CTW)) u_ckpt (
        .clk  (clk),
        .we   (br_fire),
        .waddr(br_tag),
        .wdata(ck_wdata),
        .raddr(s_q.head),
        .rdata(ck_rdata)
    );

    assign {snap_map, snap_zf} = ck_rdata;

    // ---- handshakes -----------------------------------------------------
    assign need     = slots_needed(rn_mask, rn_zero, rn_uclr);
    assign rn_ready = nfree >= FW'(need);
    assign br_ready = s_q.cnt < (CTW+1)'(NCKPT);
    assign br_tag   = s_q.head + s_q.cnt[CTW-1:0];
    assign flush    = rs_valid && rs_mispredict;
    assign rn_fire  = rn_valid && rn_ready && !flush;
    assign br_fire  = br_valid && br_ready && !flush;

    // ---- per-half action decode -----------------------------------------
    always_comb begin
        for (int h = 0; h < 2; h++) begin
            if (rn_uclr)
                act[h] = (h == HALF_HI) ? ACT_ZERO : ACT_KEEP;
            else if (rn_mask[h])
                act[h] = rn_zero ? ACT_ZERO : ACT_ALLOC;
            else if (h == HALF_HI && rn_mask[HALF_LO])
                act[h] = ACT_ZERO;   // narrow write clears the upper half
            else
                act[h] = ACT_KEEP;
        end
        pick[HALF_LO] = first_idx;
        pick[HALF_HI] = (act[HALF_LO] == ACT_ALLOC) ? second_idx : first_idx;
    end

    // ---- next state -----------------------------------------------------
    always_comb begin
        s_d  = s_q;
        rel  = '0;
        take = '0;
        yidx = '0;
        if (flush) begin
            s_d.map  = snap_map;
            s_d.zf   = snap_zf;
            s_d.held = '0;
            s_d.cnt  = '0;
            // no younger checkpoint survives, so every slot not named by the
            // restored map is free
            s_d.free = '1;
            for (int a = 0; a < NARCH; a++)
                for (int h = 0; h < 2; h++)
                    if (!snap_zf[a][h]) s_d.free[snap_map[a][h]] = 1'b0;
        end else begin
            if (rs_valid) begin
                s_d.free             = s_d.free | s_q.held[s_q.head];
                s_d.held[s_q.head]   = '0;
                s_d.head             = s_q.head + 1'b1;
                s_d.cnt              = s_q.cnt - 1'b1;
            end
            if (rn_fire) begin
                for (int h = 0; h < 2; h++) begin
                    if (act[h] != ACT_KEEP) begin
                        if (!s_q.zf[rn_dst][h]) rel[s_q.map[rn_dst][h]] = 1'b1;
                        if (act[h] == ACT_ALLOC) begin
                            s_d.map[rn_dst][h] = pick[h];
                            s_d.zf[rn_dst][h]  = 1'b0;
                            take[pick[h]]      = 1'b1;
                        end else begin
                            s_d.zf[rn_dst][h]  = 1'b1;
                        end
                    end
                end
                s_d.free = s_d.free & ~take;
                if (s_d.cnt != '0) begin
                    yidx = s_d.head + s_d.cnt[CTW-1:0] - 1'b1;
                    s_d.held[yidx] = s_d.held[yidx] | rel;
                end else begin
                    s_d.free = s_d.free | rel;
                end
            end
            if (br_fire) s_d.cnt = s_d.cnt + 1'b1;
        end
        ck_wdata = {s_d.map, s_d.zf};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.map  <= '0;
            s_q.zf   <= '1;
            s_q.free <= '1;
            s_q.held <= '0;
            s_q.head <= '0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---- lookup port ----------------------------------------------------
    assign lk_lo_slot = s_q.map[lk_idx][HALF_LO];
    assign lk_lo_zero = s_q.zf[lk_idx][HALF_LO];
    assign lk_hi_slot = s_q.map[lk_idx][HALF_HI];
    assign lk_hi_zero = s_q.zf[lk_idx][HALF_HI];

    // ---- assertions -----------------------------------------------------
    logic [NPHYS-1:0] owned;
    logic             clash;

    always_comb begin
        owned = '0;
        clash = 1'b0;
        for (int a = 0; a < NARCH; a++)
            for (int h = 0; h < 2; h++)
                if (!s_q.zf[a][h]) begin
                    if (owned[s_q.map[a][h]] || s_q.free[s_q.map[a][h]]) clash = 1'b1;
                    owned[s_q.map[a][h]] = 1'b1;
                end
    end

    a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

    a_r3_zero_takes_none: assert property (@(posedge clk) disable iff (!rst_n)
        rn_fire && rn_zero && !rn_uclr
        |=> $countones(s_q.free) >= $past($countones(s_q.free)));

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rn_fire && rn_uclr
        |=> s_q.zf[$past(rn_dst)][HALF_HI]
            && s_q.map[$past(rn_dst)][HALF_LO] == $past(s_q.map[rn_dst][HALF_LO]));

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rn_valid && !rn_ready && !flush |=> $stable(s_q.map) && $stable(s_q.zf));

    a_r9_ckpt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !br_ready |=> s_q.cnt <= $past(s_q.cnt));

    a_r10_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (s_q.cnt != '0) && (rs_tag == s_q.head));

    a_r11_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> s_q.cnt == '0);

endmodule

// File: tb/vrz_rename_test.sv
`timescale 1ns/1ps
module vrz_rename_test;

    localparam int CLK_PERIOD = 10;
    localparam int NARCH = 4;
    localparam int NPHYS = 10;
    localparam int NCKPT = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rn_valid, rn_zero, rn_uclr;
    logic [1:0] rn_dst, rn_mask;
    logic       rn_ready;
    logic       br_valid, br_ready;
    logic [1:0] br_tag;
    logic       rs_valid, rs_mispredict;
    logic [1:0] rs_tag;
    logic [1:0] lk_idx;
    logic [3:0] lk_lo_slot, lk_hi_slot;
    logic       lk_lo_zero, lk_hi_zero;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrz_rename #(.NARCH(NARCH), .NPHYS(NPHYS), .NCKPT(NCKPT)) uut (
        .clk(clk), .rst_n(rst_n),
        .rn_valid(rn_valid), .rn_dst(rn_dst), .rn_mask(rn_mask),
        .rn_zero(rn_zero), .rn_uclr(rn_uclr), .rn_ready(rn_ready),
        .br_valid(br_valid), .br_ready(br_ready), .br_tag(br_tag),
        .rs_valid(rs_valid), .rs_tag(rs_tag), .rs_mispredict(rs_mispredict),
        .lk_idx(lk_idx), .lk_lo_slot(lk_lo_slot), .lk_lo_zero(lk_lo_zero),
        .lk_hi_slot(lk_hi_slot), .lk_hi_zero(lk_hi_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // lookup one register; slots compared only for live halves
    task automatic expect_reg(input int idx, input int lo, input bit loz,
                              input int hi, input bit hiz, input string req);
        lk_idx = 2'(idx);
        #1;
        check(lk_lo_zero == loz, req, $sformatf("r%0d lower zero", idx), int'(lk_lo_zero), int'(loz));
        check(lk_hi_zero == hiz, req, $sformatf("r%0d upper zero", idx), int'(lk_hi_zero), int'(hiz));
        if (!loz) check(int'(lk_lo_slot) == lo, req, $sformatf("r%0d lower slot", idx), int'(lk_lo_slot), lo);
        if (!hiz) check(int'(lk_hi_slot) == hi, req, $sformatf("r%0d upper slot", idx), int'(lk_hi_slot), hi);
    endtask

    task automatic ready_for(input int mask, input bit z, input bit exp, input string req);
        rn_mask = 2'(mask); rn_zero = z; rn_uclr = 1'b0;
        #1;
        check(rn_ready == exp, req, $sformatf("rn_ready mask=%0d zero=%0d", mask, z), int'(rn_ready), int'(exp));
        rn_mask = 2'b00; rn_zero = 1'b0;
    endtask

    // one rename offered for one cycle (starts and ends at a falling edge)
    task automatic rename(input int dst, input int mask, input bit z, input bit u);
        rn_valid = 1'b1; rn_dst = 2'(dst); rn_mask = 2'(mask); rn_zero = z; rn_uclr = u;
        @(negedge clk);
        rn_valid = 1'b0; rn_mask = 2'b00; rn_zero = 1'b0; rn_uclr = 1'b0;
    endtask

    task automatic branch(input int exp_tag, input string req);
        #1;
        check(int'(br_tag) == exp_tag, req, "br_tag", int'(br_tag), exp_tag);
        br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic resolve(input int tag, input bit mis);
        rs_valid = 1'b1; rs_tag = 2'(tag); rs_mispredict = mis;
        @(negedge clk);
        rs_valid = 1'b0; rs_mispredict = 1'b0;
    endtask

    task automatic t_reset();
        for (int r = 0; r < NARCH; r++) expect_reg(r, 0, 1'b1, 0, 1'b1, "R1");
        ready_for(3, 1'b0, 1'b1, "R1");
        check(br_ready == 1'b1, "R1", "br_ready", int'(br_ready), 1);
        check(br_tag == 2'd0, "R1", "br_tag", int'(br_tag), 0);
    endtask

    task automatic t_alloc();
        rename(0, 3, 1'b0, 1'b0);
        expect_reg(0, 0, 1'b0, 1, 1'b0, "R2");
        rename(1, 1, 1'b0, 1'b0);
        expect_reg(1, 2, 1'b0, 0, 1'b1, "R4");
        rename(1, 3, 1'b0, 1'b0);
        expect_reg(1, 3, 1'b0, 4, 1'b0, "R2");
        rename(2, 1, 1'b0, 1'b0);                 // released slot 2 is lowest
        expect_reg(2, 2, 1'b0, 0, 1'b1, "R6");
    endtask

    task automatic t_zero();
        rename(0, 3, 1'b1, 1'b0);
        expect_reg(0, 0, 1'b1, 0, 1'b1, "R3");
        rename(1, 1, 1'b0, 1'b0);                 // narrow write drops slot 4
        expect_reg(1, 0, 1'b0, 0, 1'b1, "R4");
        rename(3, 3, 1'b0, 1'b0);
        expect_reg(3, 1, 1'b0, 3, 1'b0, "R6");
    endtask

    task automatic t_uclr();
        rename(3, 0, 1'b0, 1'b1);
        expect_reg(3, 1, 1'b0, 0, 1'b1, "R5");
        rename(0, 1, 1'b0, 1'b0);                 // takes the slot just released
        expect_reg(0, 3, 1'b0, 0, 1'b1, "R5");
    endtask

    task automatic t_hold();
        branch(0, "R9");
        rename(0, 3, 1'b0, 1'b0);
        rename(1, 3, 1'b0, 1'b0);
        rename(2, 3, 1'b0, 1'b0);
        expect_reg(2, 8, 1'b0, 9, 1'b0, "R10");
        ready_for(3, 1'b0, 1'b0, "R8");
        ready_for(1, 1'b0, 1'b0, "R8");
        rename(3, 3, 1'b0, 1'b0);                 // stalled, must not apply
        expect_reg(3, 1, 1'b0, 0, 1'b1, "R8");
        ready_for(3, 1'b1, 1'b1, "R3");
        rename(3, 3, 1'b1, 1'b0);
        expect_reg(3, 0, 1'b1, 0, 1'b1, "R3");
        ready_for(1, 1'b0, 1'b0, "R10");          // released slots still parked
        resolve(0, 1'b0);
        ready_for(3, 1'b0, 1'b1, "R10");
        rename(3, 3, 1'b0, 1'b0);
        expect_reg(3, 0, 1'b0, 1, 1'b0, "R10");
    endtask

    task automatic t_mispredict();
        branch(1, "R9");
        rename(0, 0, 1'b0, 1'b1);                 // wrong-path upper clear
        rename(1, 1, 1'b0, 1'b0);
        rename(2, 2, 1'b0, 1'b0);
        expect_reg(2, 8, 1'b0, 3, 1'b0, "R11");
        ready_for(1, 1'b0, 1'b0, "R11");
        // mispredict together with a zeroing idiom that must be discarded
        rn_valid = 1'b1; rn_dst = 2'd3; rn_mask = 2'b11; rn_zero = 1'b1;
        resolve(1, 1'b1);
        rn_valid = 1'b0; rn_mask = 2'b00; rn_zero = 1'b0;
        expect_reg(0, 4, 1'b0, 5, 1'b0, "R11");
        expect_reg(1, 6, 1'b0, 7, 1'b0, "R11");
        expect_reg(2, 8, 1'b0, 9, 1'b0, "R11");
        expect_reg(3, 0, 1'b0, 1, 1'b0, "R11");
        rename(3, 3, 1'b0, 1'b0);
        expect_reg(3, 2, 1'b0, 3, 1'b0, "R11");
    endtask

    task automatic t_limit();
        branch(1, "R9");
        branch(2, "R9");
        branch(3, "R9");
        branch(0, "R9");
        #1;
        check(br_ready == 1'b0, "R9", "br_ready when full", int'(br_ready), 0);
        br_valid = 1'b1;                          // dropped
        @(negedge clk);
        br_valid = 1'b0;
        resolve(1, 1'b0);
        #1;
        check(br_ready == 1'b1, "R9", "br_ready after one resolve", int'(br_ready), 1);
        resolve(2, 1'b0);
        resolve(3, 1'b0);
        resolve(0, 1'b0);
        #1;
        check(br_tag == 2'd1, "R9", "br_tag after drain", int'(br_tag), 1);
        check(br_ready == 1'b1, "R9", "br_ready after drain", int'(br_ready), 1);
        expect_reg(0, 4, 1'b0, 5, 1'b0, "R7");
        expect_reg(1, 6, 1'b0, 7, 1'b0, "R7");
        expect_reg(2, 8, 1'b0, 9, 1'b0, "R7");
        expect_reg(3, 2, 1'b0, 3, 1'b0, "R7");
    endtask

    initial begin
        rst_n = 1'b0;
        rn_valid = 1'b0; rn_dst = '0; rn_mask = '0; rn_zero = 1'b0; rn_uclr = 1'b0;
        br_valid = 1'b0; rs_valid = 1'b0; rs_tag = '0; rs_mispredict = 1'b0;
        lk_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc();
        t_zero();
        t_uclr();
        t_hold();
        t_mispredict();
        t_limit();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule